// File: doc/BRIEF.md
# Multi-Rate Down-Link Electrical Port Serializer

This block drives one group of eight down-link electrical outputs from a 320 MHz bit clock. Once per 40 MHz frame it is handed a 16-bit slice of the frame's user payload, together with a frame strobe. It spreads that slice over its serial outputs in the format that the group's rate setting selects. It can drive eight links at 80 Mb/s with 2 bits each, four links at 160 Mb/s with 4 bits each, or two links at 320 Mb/s with 8 bits each. Three bonded modes are also available. In these, two, four or eight outputs together form one lane, and the lane carries all 16 bits with the bits interleaved across its links.

Every active output has a forwarded clock beside it. The forwarded clock is high during even-numbered bits and low during odd-numbered bits, so it has one rising edge at the start of every frame and runs at a frequency proportional to the link rate. Outputs that the selected mode does not use, and all outputs in the off setting, are held low. The rate setting and the slice are taken only on the frame strobe, so a frame is never split between two formats. Each group of an enclosing transceiver instantiates one copy of this block, and each copy has its own setting.

Top module: `eser_group_tx`

## Requirements
- R1: While reset is high, and after reset until the first frame strobe, every data and clock output is 0.
- R2: The mode code and the slice are captured only in a cycle where the frame strobe is high. Changes on either input in other cycles do not affect the outputs until the next strobe.
- R3: Mode code 1 (eight links at 80 Mb/s): link k sends slice bit 15-2k and then bit 14-2k. Each bit is held for 4 cycles.
- R4: Mode code 2 (four links at 160 Mb/s): link k sends slice bits 15-4k down to 12-4k, most significant first. Each bit is held for 2 cycles.
- R5: Mode code 3 (two links at 320 Mb/s): link k sends slice bits 15-8k down to 8-8k, one bit per cycle, most significant first.
- R6: Outputs above the number of links that the captured mode uses hold data 0 and clock 0.
- R7: Mode code 0 (off) and the reserved code 7 hold all data and clock outputs at 0 for the whole frame.
- R8: Mode codes 4, 5 and 6 bond N = 2, 4 or 8 links into one lane. At bit time t, link k sends slice bit 15-(t*N+k), and each bit is held for N/2 cycles.
- R9: On an active link, the forwarded clock is 1 while an even-numbered bit of the frame is shown and 0 while an odd-numbered bit is shown.
- R10: A strobe sampled at clock edge E shows bit 0 of the new frame on the outputs after edge E+1. Each later cycle advances one phase of the 8-cycle frame. A strobe that arrives early restarts the frame at phase 0, and without a strobe the phase wraps from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 320 MHz bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| frame_stb_i | input | 1 | One-cycle pulse marking a frame start |
| mode_cfg_i | input | 3 | Rate and bonding code, captured on the strobe |
| slice_i | input | SLICE_W (16) | Payload slice for the coming frame |
| ser_dout_o | output | LINKS (8) | Serial data, one bit per link |
| ser_lclk_o | output | LINKS (8) | Forwarded clock, one per link |

## Verification
The bench builds the block with its default values: eight links, a 16-bit slice and an 8-cycle frame. With these values, every rate mode, every bonded lane width (including the eight-link lane) and the quiet unused outputs of the partial modes all occur. Directed frames cover all-ones, single-bit and alternating slices, input changes in the middle of a frame, an early strobe and a missing strobe. Random frames then mix all eight mode codes, with noise placed on the inputs between strobes.

// File: rtl/eser_pkg.sv
package eser_pkg;

    typedef enum logic [2:0] {
        MODE_OFF    = 3'd0,
        MODE_X8_80  = 3'd1,
        MODE_X4_160 = 3'd2,
        MODE_X2_320 = 3'd3,
        MODE_LANE2  = 3'd4,
        MODE_LANE4  = 3'd5,
        MODE_LANE8  = 3'd6
    } eser_mode_e;

    // How the slice is spread: enabled, bonded, log2 of links used
    typedef struct packed {
        logic       on;
        logic       lane;
        logic [1:0] nlog;
    } eser_layout_t;

    // Reserved code folds onto the off setting
    function automatic eser_mode_e to_mode(input logic [2:0] code);
        if (code == 3'd7) return MODE_OFF;
        return eser_mode_e'(code);
    endfunction

    function automatic eser_layout_t layout_of(input eser_mode_e m);
        eser_layout_t r;
        r = '0;
        case (m)
            MODE_X8_80:  r = '{on: 1'b1, lane: 1'b0, nlog: 2'd3};
            MODE_X4_160: r = '{on: 1'b1, lane: 1'b0, nlog: 2'd2};
            MODE_X2_320: r = '{on: 1'b1, lane: 1'b0, nlog: 2'd1};
            MODE_LANE2:  r = '{on: 1'b1, lane: 1'b1, nlog: 2'd1};
            MODE_LANE4:  r = '{on: 1'b1, lane: 1'b1, nlog: 2'd2};
            MODE_LANE8:  r = '{on: 1'b1, lane: 1'b1, nlog: 2'd3};
            default:     r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/eser_frame_ctrl.sv
module eser_frame_ctrl
    import eser_pkg::*;
#(
    parameter int SLICE_W   = 16,
    parameter int FRAME_CYC = 8,
    localparam int PH_W     = $clog2(FRAME_CYC)
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               frame_stb_i,
    input  logic [2:0]         mode_cfg_i,
    input  logic [SLICE_W-1:0] slice_i,
    output eser_mode_e         mode_q_o,
    output logic [SLICE_W-1:0] slice_q_o,
    output logic [PH_W-1:0]    phase_q_o
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_CYC - 1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q_o  <= MODE_OFF;
            slice_q_o <= '0;
            phase_q_o <= '0;
        end else if (frame_stb_i) begin
            mode_q_o  <= to_mode(mode_cfg_i);
            slice_q_o <= slice_i;
            phase_q_o <= '0;
        end else begin
            phase_q_o <= (phase_q_o == PH_LAST) ? '0 : phase_q_o + 1'b1;
        end
    end

    // R2: setting and payload stay put between strobes
    p_hold_between_strobes_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !frame_stb_i |=> ($stable(mode_q_o) && $stable(slice_q_o)));

    // R10: a strobe restarts the frame
    p_restart_on_strobe_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_stb_i |=> (phase_q_o == '0));

    // R10: without a strobe the phase steps by one
    p_phase_step_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (!frame_stb_i && phase_q_o != PH_LAST) |=> (phase_q_o == $past(phase_q_o) + 1'b1));

endmodule

// File: rtl/eser_link_pick.sv
module eser_link_pick
    import eser_pkg::*;
#(
    parameter int LINK_IDX  = 0,
    parameter int SLICE_W   = 16,
    parameter int FRAME_CYC = 8,
    localparam int PH_W     = $clog2(FRAME_CYC),
    localparam int SL_LOG   = $clog2(SLICE_W)
) (
    input  eser_layout_t       lay_i,
    input  logic [PH_W-1:0]    phase_i,
    input  logic [SLICE_W-1:0] slice_i,
    output logic               bit_o,
    output logic               clk_o
);

    int                blog;
    int                hlog;
    logic [PH_W-1:0]   t;
    logic [SL_LOG-1:0] idx;
    logic              act;

    always_comb begin
        blog = 0;
        hlog = 0;
        t    = '0;
        idx  = '0;
        act  = 1'b0;
        if (lay_i.on) begin
            // bits per link = 2^blog, cycles per bit = 2^hlog
            blog = SL_LOG - int'(lay_i.nlog);
            hlog = PH_W - blog;
            t    = phase_i >> hlog;
            act  = (LINK_IDX >> lay_i.nlog) == 0;
            if (lay_i.lane)
                idx = SL_LOG'((int'(t) << lay_i.nlog) + LINK_IDX);
            else
                idx = SL_LOG'((LINK_IDX << blog) + int'(t));
        end
        bit_o = act & slice_i[SL_LOG'(SLICE_W - 1) - idx];
        clk_o = act & ~t[0];
    end

endmodule

// File: rtl/eser_out_reg.sv
module eser_out_reg #(
    parameter int LINKS = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [LINKS-1:0] d_nxt_i,
    input  logic [LINKS-1:0] c_nxt_i,
    output logic [LINKS-1:0] dout_o,
    output logic [LINKS-1:0] lclk_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dout_o <= '0;
            lclk_o <= '0;
        end else begin
            dout_o <= d_nxt_i;
            lclk_o <= c_nxt_i;
        end
    end

endmodule

// File: rtl/eser_group_tx.sv
module eser_group_tx
    import eser_pkg::*;
#(
    parameter int LINKS     = 8,
    parameter int SLICE_W   = 16,
    parameter int FRAME_CYC = 8
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               frame_stb_i,
    input  logic [2:0]         mode_cfg_i,
    input  logic [SLICE_W-1:0] slice_i,
    output logic [LINKS-1:0]   ser_dout_o,
    output logic [LINKS-1:0]   ser_lclk_o
);

    localparam int PH_W = $clog2(FRAME_CYC);

    eser_mode_e         cur_mode;
    logic [SLICE_W-1:0] slice_q;
    logic [PH_W-1:0]    phase_q;
    eser_layout_t       lay;
    logic [LINKS-1:0]   d_nxt;
    logic [LINKS-1:0]   c_nxt;

    eser_frame_ctrl #(
        .SLICE_W   (SLICE_W),
        .FRAME_CYC (FRAME_CYC)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .frame_stb_i (frame_stb_i),
        .mode_cfg_i  (mode_cfg_i),
        .slice_i     (slice_i),
        .mode_q_o    (cur_mode),
        .slice_q_o   (slice_q),
        .phase_q_o   (phase_q)
    );

    assign lay = layout_of(cur_mode);

    for (genvar k = 0; k < LINKS; k++) begin : g_link
        eser_link_pick #(
            .LINK_IDX  (k),
            .SLICE_W   (SLICE_W),
            .FRAME_CYC (FRAME_CYC)
        ) u_pick (
            .lay_i   (lay),
            .phase_i (phase_q),
            .slice_i (slice_q),
            .bit_o   (d_nxt[k]),
            .clk_o   (c_nxt[k])
        );
    end

    eser_out_reg #(
        .LINKS (LINKS)
    ) u_oreg (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .d_nxt_i (d_nxt),
        .c_nxt_i (c_nxt),
        .dout_o  (ser_dout_o),
        .lclk_o  (ser_lclk_o)
    );

    // R1: reset clears every output on the next edge
    p_reset_quiet_r1: assert property (@(posedge clk_i)
        rst_i |=> (ser_dout_o == '0 && ser_lclk_o == '0));

    // R7: off setting keeps the group silent
    p_off_quiet_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_mode == MODE_OFF) |=> (ser_dout_o == '0 && ser_lclk_o == '0));

    // R6: two-link formats leave the upper outputs idle
    p_unused_quiet_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_mode == MODE_X2_320 || cur_mode == MODE_LANE2)
        |=> (ser_dout_o[LINKS-1:2] == '0 && ser_lclk_o[LINKS-1:2] == '0));

    // R9: forwarded clock is high when a frame begins
    p_clk_frame_start_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == '0 && cur_mode != MODE_OFF) |=> ser_lclk_o[0]);

    // R8: all links of an eight-wide lane share one clock phase
    p_lane_clk_match_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_mode == MODE_LANE8) |=> (ser_lclk_o == {LINKS{ser_lclk_o[0]}}));

endmodule

// File: tb/eser_group_tx_bench.sv
module eser_group_tx_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic [2:0]  mode_cfg = 3'd0;
    logic [15:0] slice_in = 16'h0;
    logic [7:0]  ser_dout;
    logic [7:0]  ser_lclk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [2:0]  m_mode  = 3'd0;
    logic [15:0] m_slice = 16'h0;
    int          m_ph    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eser_group_tx u_eser_group_tx (
        .clk_i       (clk),
        .rst_i       (rst),
        .frame_stb_i (frame_stb),
        .mode_cfg_i  (mode_cfg),
        .slice_i     (slice_in),
        .ser_dout_o  (ser_dout),
        .ser_lclk_o  (ser_lclk)
    );

    function automatic int links_of(input logic [2:0] m);
        case (m)
            3'd1, 3'd6: return 8;
            3'd2, 3'd5: return 4;
            3'd3, 3'd4: return 2;
            default:    return 0;
        endcase
    endfunction

    // Expected {clock, data} for a mode, a slice and a frame phase
    function automatic logic [15:0] expect_out(input logic [2:0] m, input logic [15:0] s, input int ph);
        logic [7:0] d;
        logic [7:0] c;
        int n;
        bit lane;
        d = '0;
        c = '0;
        n = links_of(m);
        lane = (m >= 3'd4) && (m <= 3'd6);
        if (n > 0) begin
            int b;
            int h;
            int t;
            b = 16 / n;
            h = 8 / b;
            t = ph / h;
            for (int k = 0; k < n; k++) begin
                int idx;
                idx = lane ? (t * n + k) : (k * b + t);
                d[k] = s[15 - idx];
                c[k] = (t % 2) == 0;
            end
        end
        return {c, d};
    endfunction

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4, 3'd5, 3'd6: return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    // One clock cycle: drive, let the edge pass, update the model, compare at the falling edge
    task automatic step(input logic r, input logic stb, input logic [15:0] d,
                        input logic [2:0] m, input string tag);
        logic [15:0] exp;
        logic [7:0]  mask;
        logic [2:0]  shown;
        rst = r;
        frame_stb = stb;
        slice_in = d;
        mode_cfg = m;
        @(posedge clk);
        shown = r ? 3'd0 : m_mode;
        exp = r ? 16'h0 : expect_out(m_mode, m_slice, m_ph);
        mask = 8'((1 << links_of(shown)) - 1);
        if (r) begin
            m_mode = 3'd0;
            m_slice = 16'h0;
            m_ph = 0;
        end else if (stb) begin
            m_mode = (m == 3'd7) ? 3'd0 : m;
            m_slice = d;
            m_ph = 0;
        end else begin
            m_ph = (m_ph + 1) % 8;
        end
        @(negedge clk);
        if (tag != "") begin
            check(tag, "outputs", ser_dout, exp[7:0]);
            check(tag, "clocks", ser_lclk, exp[15:8]);
        end else begin
            check(tag_of(shown), "data", ser_dout & mask, exp[7:0] & mask);
            check((shown == 3'd0) ? "R7" : "R9", "clock", ser_lclk & mask, exp[15:8] & mask);
            if (mask != 8'hFF)
                check("R6", "unused", {ser_dout & ~mask, ser_lclk & ~mask}, 8'h00);
        end
    endtask

    task automatic frame(input logic [2:0] m, input logic [15:0] d, input string tag, input bit noise);
        step(1'b0, 1'b1, d, m, tag);
        for (int i = 1; i < 8; i++) begin
            if (noise) step(1'b0, 1'b0, 16'($urandom), 3'($urandom), tag);
            else       step(1'b0, 1'b0, d, m, tag);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R1: reset and idle before the first strobe
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 16'hFFFF, 3'd1, "R1");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 16'hFFFF, 3'd1, "R1");

        // R3, R4, R5, R8, R9, R6: every mode over several patterns
        for (int m = 1; m <= 6; m++) begin
            frame(3'(m), 16'hA5C3, "", 1'b0);
            frame(3'(m), 16'h8001, "", 1'b0);
            frame(3'(m), 16'hFFFF, "", 1'b0);
            frame(3'(m), 16'h1234, "", 1'b0);
        end

        // R2: mid-frame setting and payload changes are ignored
        frame(3'd1, 16'h0F0F, "R2", 1'b1);
        frame(3'd6, 16'hC3A5, "R2", 1'b1);
        frame(3'd3, 16'h5AA5, "R2", 1'b1);

        // R7: off and reserved codes
        frame(3'd0, 16'hFFFF, "", 1'b0);
        frame(3'd2, 16'hFFFF, "", 1'b0);
        frame(3'd7, 16'hFFFF, "", 1'b0);

        // R10: early strobe restarts the frame, a missing strobe wraps the phase
        step(1'b0, 1'b1, 16'hB00B, 3'd3, "R10");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 16'h0, 3'd0, "R10");
        step(1'b0, 1'b1, 16'h9C6E, 3'd5, "R10");
        for (int i = 0; i < 15; i++) step(1'b0, 1'b0, 16'h0, 3'd0, "R10");

        // Random frames across every code
        for (int f = 0; f < 150; f++)
            frame(3'($urandom), 16'($urandom), "", ($urandom % 2) == 1);

        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_run();
    end

endmodule